// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches two single-cycle edge pulses: one from the reference path and one from the feedback divider, as they reach the phase-frequency detector. Both pulses are synchronous to a fast sampling clock. For each detector period it counts the sampling ticks between the two rising edges, in either order, and decides whether that cycle was close enough to count toward lock.

The lock flag has hysteresis. To rise, it needs an unbroken run of in-window cycles. The length of that run is chosen by a 2-bit select. Once the flag is set, it falls only when a cycle's skew goes past a wider loss threshold. A range bit picks a tight or a loose pair of thresholds, and a disable bit forces the detector off. The block has no streaming data path. Every pin is a plain control or status level, or a single-cycle pulse, and none of them has back-pressure.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all state clears, and `lock_flag` reads 0 after that edge.
- R2: The skew of a detector cycle is the number of clock edges between the edge that samples the first pulse and the edge that samples its partner, whichever input comes first. Pulses sampled at the same edge give a skew of 0.
- R3: `run_sel` sets how many consecutive in-window cycles raise the flag: 2'b00 gives 5, 2'b01 gives 16, 2'b10 gives 64 and 2'b11 gives 255.
- R4: A cycle is in-window when its skew is strictly below the lock window: 16 ticks when `win_low`=0 and 4 ticks when `win_low`=1. While the flag is low, any cycle with a skew at or above the window clears the run count to zero.
- R5: While the flag is high, it stays high for any skew up to and including the loss threshold: 32 ticks when `win_low`=0 and 8 ticks when `win_low`=1. A cycle with a larger skew clears the flag, and the run count then restarts from zero.
- R6: If the same input pulses twice with no partner in between, that cycle counts as exceeding both thresholds. The second pulse then opens a new measurement.
- R7: While `lock_off`=1, `lock_flag` is 0 from the next edge on and the run count is cleared. Cycles that complete while it is high have no effect on the flag.
- R8: `lock_flag` changes only at the second rising edge after the edge that samples the pulse closing a cycle. With no cycle closing, it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_edge | input | 1 | One-cycle pulse for each reference rising edge |
| fb_edge | input | 1 | One-cycle pulse for each feedback rising edge |
| run_sel | input | 2 | Selects the required run length (5/16/64/255) |
| win_low | input | 1 | 0: wide thresholds (16/32), 1: tight thresholds (4/8) |
| lock_off | input | 1 | 1 forces the detector off |
| lock_flag | output | 1 | Registered lock indication |

## Verification
Each cycle's result reaches `lock_flag` two edges after the edge that samples its closing pulse. The bench therefore reads the flag at the falling edge right after that sampling edge, where it must still show the old decision, and again one falling edge later, where it must show the new one. A change of `lock_off` takes one edge, so the flag is read at the next falling edge. The sweep covers every run length and both ranges. For each of them it steps the skew to the boundary values of the window and of the loss threshold, and the bench computes the expected flag from those thresholds.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  localparam int SKEW_W = 8;
  localparam int SKEW_MAX = (1 << SKEW_W) - 1;

  typedef logic [SKEW_W-1:0] skew_t;

  typedef struct packed {
    logic  valid;
    logic  orphan;
    skew_t diff;
  } skew_meas_t;

  typedef enum logic [1:0] {
    MTR_IDLE,
    MTR_REF_OPEN,
    MTR_FB_OPEN
  } meter_st_e;

  function automatic skew_t run_target(input logic [1:0] sel);
    int t;
    if (sel == 2'b11)      t = SKEW_MAX;
    else if (sel == 2'b00) t = 5;
    else                   t = 1 << (2 * int'(sel) + 2);
    return skew_t'(t);
  endfunction

  function automatic skew_t sat_inc(input skew_t v);
    return (v == skew_t'(SKEW_MAX)) ? v : v + skew_t'(1);
  endfunction

endpackage

// File: rtl/edge_skew_meter.sv
module edge_skew_meter
  import pll_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_edge,
  input  logic       fb_edge,
  output skew_meas_t meas
);

  meter_st_e st;
  skew_t     ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= MTR_IDLE;
      ticks <= '0;
      meas  <= '0;
    end else begin
      meas <= '0;
      unique case (st)
        MTR_IDLE: begin
          if (ref_edge && fb_edge) begin
            meas <= '{valid: 1'b1, orphan: 1'b0, diff: '0};
          end else if (ref_edge) begin
            st    <= MTR_REF_OPEN;
            ticks <= skew_t'(1);
          end else if (fb_edge) begin
            st    <= MTR_FB_OPEN;
            ticks <= skew_t'(1);
          end
        end
        MTR_REF_OPEN: begin
          if (fb_edge) begin
            meas <= '{valid: 1'b1, orphan: 1'b0, diff: ticks};
            if (ref_edge) ticks <= skew_t'(1);
            else          st    <= MTR_IDLE;
          end else if (ref_edge) begin
            meas  <= '{valid: 1'b1, orphan: 1'b1, diff: ticks};
            ticks <= skew_t'(1);
          end else begin
            ticks <= sat_inc(ticks);
          end
        end
        MTR_FB_OPEN: begin
          if (ref_edge) begin
            meas <= '{valid: 1'b1, orphan: 1'b0, diff: ticks};
            if (fb_edge) ticks <= skew_t'(1);
            else         st    <= MTR_IDLE;
          end else if (fb_edge) begin
            meas  <= '{valid: 1'b1, orphan: 1'b1, diff: ticks};
            ticks <= skew_t'(1);
          end else begin
            ticks <= sat_inc(ticks);
          end
        end
        default: st <= MTR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lock_limit_sel.sv
module lock_limit_sel
  import pll_lock_pkg::*;
#(
  parameter int HI_WIN  = 16,
  parameter int HI_LOSS = 32,
  parameter int LO_WIN  = 4,
  parameter int LO_LOSS = 8
) (
  input  logic [1:0] run_sel,
  input  logic       win_low,
  output skew_t      lock_win,
  output skew_t      loss_thr,
  output skew_t      run_tgt
);

  localparam skew_t HI_WIN_T  = skew_t'(HI_WIN);
  localparam skew_t HI_LOSS_T = skew_t'(HI_LOSS);
  localparam skew_t LO_WIN_T  = skew_t'(LO_WIN);
  localparam skew_t LO_LOSS_T = skew_t'(LO_LOSS);

  always_comb begin
    lock_win = win_low ? LO_WIN_T  : HI_WIN_T;
    loss_thr = win_low ? LO_LOSS_T : HI_LOSS_T;
    run_tgt  = run_target(run_sel);
  end

endmodule

// File: rtl/lock_hysteresis.sv
module lock_hysteresis
  import pll_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  skew_meas_t meas,
  input  skew_t      lock_win,
  input  skew_t      loss_thr,
  input  skew_t      run_tgt,
  input  logic       lock_off,
  output logic       lock_flag,
  output skew_t      run_cnt
);

  logic  in_win;
  logic  lost;
  skew_t run_nxt;

  always_comb begin
    in_win  = meas.valid && !meas.orphan && (meas.diff < lock_win);
    lost    = meas.valid && (meas.orphan || (meas.diff > loss_thr));
    run_nxt = run_cnt + skew_t'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || lock_off) begin
      lock_flag <= 1'b0;
      run_cnt   <= '0;
    end else if (!lock_flag) begin
      if (in_win) begin
        if (run_nxt >= run_tgt) begin
          lock_flag <= 1'b1;
          run_cnt   <= '0;
        end else begin
          run_cnt <= run_nxt;
        end
      end else if (meas.valid) begin
        run_cnt <= '0;
      end
    end else if (lost) begin
      lock_flag <= 1'b0;
      run_cnt   <= '0;
    end
  end

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int HI_WIN  = 16,
  parameter int HI_LOSS = 32,
  parameter int LO_WIN  = 4,
  parameter int LO_LOSS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_edge,
  input  logic       fb_edge,
  input  logic [1:0] run_sel,
  input  logic       win_low,
  input  logic       lock_off,
  output logic       lock_flag
);

  skew_meas_t meas_w;
  skew_t      lock_win_w;
  skew_t      loss_thr_w;
  skew_t      run_tgt_w;
  skew_t      run_cnt_w;

  edge_skew_meter u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .meas     (meas_w)
  );

  lock_limit_sel #(
    .HI_WIN  (HI_WIN),
    .HI_LOSS (HI_LOSS),
    .LO_WIN  (LO_WIN),
    .LO_LOSS (LO_LOSS)
  ) u_limits (
    .run_sel  (run_sel),
    .win_low  (win_low),
    .lock_win (lock_win_w),
    .loss_thr (loss_thr_w),
    .run_tgt  (run_tgt_w)
  );

  lock_hysteresis u_hyst (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas      (meas_w),
    .lock_win  (lock_win_w),
    .loss_thr  (loss_thr_w),
    .run_tgt   (run_tgt_w),
    .lock_off  (lock_off),
    .lock_flag (lock_flag),
    .run_cnt   (run_cnt_w)
  );

endmodule

// File: rtl/pll_lock_monitor_checker.sv
module pll_lock_monitor_checker
  import pll_lock_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       lock_off,
  input logic       lock_flag,
  input skew_meas_t meas,
  input skew_t      lock_win,
  input skew_t      loss_thr,
  input skew_t      run_cnt
);

  logic  armed;
  logic  p_valid;
  logic  p_orph;
  skew_t p_diff;
  skew_t p_win;
  skew_t p_loss;
  logic  p_off;
  logic  p_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      p_valid <= 1'b0;
      p_orph  <= 1'b0;
      p_diff  <= '0;
      p_win   <= '0;
      p_loss  <= '0;
      p_off   <= 1'b0;
      p_flag  <= 1'b0;
    end else begin
      armed   <= 1'b1;
      p_valid <= meas.valid;
      p_orph  <= meas.orphan;
      p_diff  <= meas.diff;
      p_win   <= lock_win;
      p_loss  <= loss_thr;
      p_off   <= lock_off;
      p_flag  <= lock_flag;
    end
  end

  // R7: disabling clears flag and run count at the next edge
  p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_off |=> (!lock_flag && run_cnt == '0));

  // R4: a rise follows an in-window, non-orphan measurement
  p_rise_inwin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && lock_flag && !p_flag) |-> (p_valid && !p_orph && !p_off && p_diff < p_win));

  // R5: a fall (other than by disable) follows a skew beyond the loss threshold
  p_fall_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_flag && !lock_flag && !p_off) |-> (p_valid && (p_orph || p_diff > p_loss)));

  // R8: with no closed cycle the flag holds
  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !p_valid && !p_off) |-> (lock_flag == p_flag));

endmodule

bind pll_lock_monitor pll_lock_monitor_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock_off  (lock_off),
  .lock_flag (lock_flag),
  .meas      (meas_w),
  .lock_win  (lock_win_w),
  .loss_thr  (loss_thr_w),
  .run_cnt   (run_cnt_w)
);

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_edge = 1'b0;
  logic       fb_edge = 1'b0;
  logic [1:0] run_sel = 2'b00;
  logic       win_low = 1'b0;
  logic       lock_off = 1'b0;
  logic       lock_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  bit m_flag = 1'b0;
  int m_run = 0;

  always #10 clk = ~clk;

  pll_lock_monitor dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_edge  (ref_edge),
    .fb_edge   (fb_edge),
    .run_sel   (run_sel),
    .win_low   (win_low),
    .lock_off  (lock_off),
    .lock_flag (lock_flag)
  );

  function automatic int lw();
    return win_low ? 4 : 16;
  endfunction

  function automatic int ls();
    return win_low ? 8 : 32;
  endfunction

  function automatic int tgt();
    case (run_sel)
      2'b00:   return 5;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 255;
    endcase
  endfunction

  task automatic check(input bit got, input bit exp, input string tag, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: lock_flag=%0b expected %0b (sel=%0d low=%0b)",
               tag, what, got, exp, run_sel, win_low);
    end
  endtask

  task automatic model_meas(input bit orph, input int d);
    if (!m_flag) begin
      if (!orph && d < lw()) begin
        m_run++;
        if (m_run >= tgt()) begin
          m_flag = 1'b1;
          m_run  = 0;
        end
      end else begin
        m_run = 0;
      end
    end else if (orph || d > ls()) begin
      m_flag = 1'b0;
      m_run  = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(lock_flag, 1'b0, "R1", "flag during reset");
    rst_n = 1'b1;
    m_flag = 1'b0;
    m_run = 0;
    @(negedge clk);
    check(lock_flag, 1'b0, "R1", "flag after reset");
  endtask

  // One detector cycle with the given skew; closing pulse sampled at E0,
  // flag must be unchanged after E0 and updated after E1 (R8).
  task automatic pair(input bit ref_first, input int gap, input string tag);
    bit old_flag;
    if (gap == 0) begin
      @(negedge clk); ref_edge = 1'b1; fb_edge = 1'b1;
      @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
    end else begin
      @(negedge clk);
      if (ref_first) ref_edge = 1'b1; else fb_edge = 1'b1;
      @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
      repeat (gap - 1) @(negedge clk);
      if (ref_first) fb_edge = 1'b1; else ref_edge = 1'b1;
      @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
    end
    old_flag = m_flag;
    check(lock_flag, old_flag, "R8", "flag changed too early");
    if (!lock_off) model_meas(1'b0, gap);
    @(negedge clk);
    check(lock_flag, m_flag, tag, $sformatf("after skew %0d", gap));
    @(negedge clk);
  endtask

  task automatic orphan_seq();
    @(negedge clk); ref_edge = 1'b1;
    @(negedge clk); ref_edge = 1'b0;
    repeat (2) @(negedge clk);
    ref_edge = 1'b1;
    @(negedge clk); ref_edge = 1'b0;
    check(lock_flag, m_flag, "R8", "flag before orphan result");
    model_meas(1'b1, 0);
    @(negedge clk);
    check(lock_flag, m_flag, "R6", "after orphan reference edge");
    @(negedge clk); fb_edge = 1'b1;
    @(negedge clk); fb_edge = 1'b0;
    check(lock_flag, m_flag, "R8", "flag before partner result");
    model_meas(1'b0, 3);
    @(negedge clk);
    check(lock_flag, m_flag, "R6", "new measurement after orphan");
    @(negedge clk);
  endtask

  task automatic good_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      pair(i[0], (i % 3 == 0) ? lw() - 1 : i % lw(), tag);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        run_sel = s[1:0];
        win_low = w[0];
        do_reset();
        // R3/R2: acquire with skews 0..window-1 in both orders
        good_run(tgt() - 1, "R3");
        check(lock_flag, 1'b0, "R3", "one cycle short of run");
        good_run(1, "R3");
        check(lock_flag, 1'b1, "R3", "run length reached");
        // R5: hysteresis boundaries
        pair(1'b1, lw(), "R5");
        pair(1'b0, ls(), "R5");
        check(lock_flag, 1'b1, "R5", "held at loss threshold");
        pair(1'b1, ls() + 1, "R5");
        check(lock_flag, 1'b0, "R5", "dropped past loss threshold");
        // R4: window boundary breaks the run
        good_run(tgt() - 1, "R4");
        pair(1'b0, lw(), "R4");
        good_run(tgt() - 1, "R4");
        check(lock_flag, 1'b0, "R4", "run restarted after window miss");
        good_run(1, "R4");
        check(lock_flag, 1'b1, "R4", "locked after fresh run");
        // R6: orphan while locked
        orphan_seq();
        check(lock_flag, 1'b0, "R6", "orphan dropped lock");
        // R7: disable
        good_run(tgt(), "R7");
        @(negedge clk); lock_off = 1'b1;
        m_flag = 1'b0; m_run = 0;
        @(negedge clk);
        check(lock_flag, 1'b0, "R7", "flag low one edge after disable");
        pair(1'b1, 0, "R7");
        check(lock_flag, 1'b0, "R7", "cycle ignored while disabled");
        lock_off = 1'b0;
        good_run(tgt() - 1, "R7");
        check(lock_flag, 1'b0, "R7", "run count was cleared");
        good_run(1, "R7");
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule